// File: doc/BRIEF.md
# Memory-Mode Soft Switch Bank

This block keeps the memory-configuration flags of a small 8-bit computer as six single-bit soft switches. The CPU changes a switch by writing to an address in the low I/O page. An even offset clears the flag and the next odd offset sets it. The value written on the data bus plays no part. The current flag vector goes straight to the bank-mapping logic, which uses it to steer reads and writes between main and auxiliary memory, the zero-page bank, and internal or peripheral ROM in the Cx page.

Software checks the switches by reading a status range in the same page. Each flag has its own status address, and the flag value appears on the top data bit. The lower data bits come from a floating-bus input. The two language-card bank flags are held elsewhere. This block only reports them through two more status addresses.

Top module: `memcfg_switch_bank`

## Requirements
- R1: While `rst_n` is low, all six flags are held at 0, with no clock needed. In particular, the internal-Cx-ROM flag is clear after reset, so peripheral slot ROMs are selected.
- R2: A write to offset 2p clears flag p and a write to offset 2p+1 sets it. Here p is the bit index in `sw_flags`: 0 = 80-column store, 1 = auxiliary read, 2 = auxiliary write, 3 = internal Cx ROM, 4 = alternate zero page, 5 = slot C3 ROM. This covers offsets $00 to $0B.
- R3: The internal-ROM flag has inverted sense. A write to $06 clears `sw_flags[3]`, which selects the slot ROMs. A write to $07 sets it, which selects the internal ROM.
- R4: A switch write changes `sw_flags` only at the rising clock edge that ends the write cycle. Before that edge, `sw_flags` and the status reads still show the old value.
- R5: A write to any offset at or above $0C, and any read cycle, leaves `sw_flags` unchanged.
- R6: A read at offsets $13 to $18 places one flag on `rd_data[7]`, in this order: $13 auxiliary read, $14 auxiliary write, $15 internal Cx ROM, $16 alternate zero page, $17 slot C3 ROM, $18 80-column store.
- R7: A read at $11 places `bank2_in` on `rd_data[7]`. A read at $12 places `rdram_in` on `rd_data[7]`.
- R8: On a status read ($11 to $18), `rd_data[6:0]` equals `float_in[6:0]`. On any other read, or when no access is in progress, `rd_data` equals `float_in`.
- R9: When `io_sel` is low, no access takes place and a write-like bus state does not change `sw_flags`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_sel | input | 1 | High when the CPU is accessing the low I/O page |
| cpu_rw | input | 1 | 1 = read, 0 = write |
| cpu_addr | input | ADDR_W | Offset within the I/O page |
| bank2_in | input | 1 | Bank-2 flag from the language-card logic |
| rdram_in | input | 1 | Read-RAM flag from the language-card logic |
| float_in | input | DATA_W | Floating-bus value |
| sw_flags | output | 6 | Current switch vector (bit order as in R2) |
| rd_data | output | DATA_W | Read data byte |

## Verification
The assertions assume that one bus cycle is either a read or a write, set by `cpu_rw` and qualified by `io_sel`. They also assume the address is stable for the whole clock cycle, so a flag update always lines up with one sampled address. The bench changes every input only on the falling clock edge. It holds each access for exactly one cycle, then drops `io_sel`, so the bus is never left partway through an access at a rising edge. Reset is applied and released away from the rising edge. This keeps the reset-clear check and the next-cycle checks aligned with the cycle in which the access happened.

// File: rtl/memcfg_pkg.sv
package memcfg_pkg;
   localparam int NUM_SW     = 6;
   localparam int SW_STORE80 = 0;
   localparam int SW_AUXRD   = 1;
   localparam int SW_AUXWR   = 2;
   localparam int SW_INTCX   = 3;
   localparam int SW_ALTZP   = 4;
   localparam int SW_SLOTC3  = 5;

   localparam int OFS_WR_END = 2 * NUM_SW;   // first offset past the switch range
   localparam int OFS_BANK2  = 'h11;
   localparam int OFS_RDRAM  = 'h12;
   localparam int OFS_ST_LO  = 'h13;         // first per-switch status offset

   localparam logic [NUM_SW-1:0] SW_RESET = '0;

   // status slot k (offset OFS_ST_LO + k) -> switch index
   function automatic int status_to_sw(input int k);
      return (k + 1) % NUM_SW;
   endfunction
endpackage

// File: rtl/memcfg_wr_decode.sv
module memcfg_wr_decode
   import memcfg_pkg::*;
#(
   parameter int ADDR_W = 8
) (
   input  logic              io_sel,
   input  logic              cpu_rw,
   input  logic [ADDR_W-1:0] cpu_addr,
   output logic [NUM_SW-1:0] upd_en,
   output logic              upd_val
);
   logic wr_cyc;
   assign wr_cyc  = io_sel && !cpu_rw;
   assign upd_val = cpu_addr[0];

   for (genvar p = 0; p < NUM_SW; p++) begin : g_pair
      assign upd_en[p] = wr_cyc && (cpu_addr[ADDR_W-1:1] == (ADDR_W-1)'(p));
   end
endmodule

// File: rtl/memcfg_flag_bank.sv
module memcfg_flag_bank
   import memcfg_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_SW-1:0] upd_en,
   input  logic              upd_val,
   output logic [NUM_SW-1:0] flags
);
   for (genvar i = 0; i < NUM_SW; i++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            flags[i] <= SW_RESET[i];
         else if (upd_en[i])
            flags[i] <= upd_val;
      end
   end
endmodule

// File: rtl/memcfg_status_mux.sv
module memcfg_status_mux
   import memcfg_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 8
) (
   input  logic              io_sel,
   input  logic              cpu_rw,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [NUM_SW-1:0] flags,
   input  logic              bank2_in,
   input  logic              rdram_in,
   input  logic [DATA_W-1:0] float_in,
   output logic [DATA_W-1:0] rd_data
);
   localparam int TOP = DATA_W - 1;

   logic [NUM_SW-1:0] st_hit;
   logic [NUM_SW-1:0] st_val;

   for (genvar k = 0; k < NUM_SW; k++) begin : g_slot
      assign st_hit[k] = (cpu_addr == ADDR_W'(OFS_ST_LO + k));
      assign st_val[k] = flags[status_to_sw(k)];
   end

   always_comb begin
      rd_data = float_in;
      if (io_sel && cpu_rw) begin
         if (cpu_addr == ADDR_W'(OFS_BANK2))
            rd_data[TOP] = bank2_in;
         else if (cpu_addr == ADDR_W'(OFS_RDRAM))
            rd_data[TOP] = rdram_in;
         else if (|st_hit)
            rd_data[TOP] = |(st_hit & st_val);
      end
   end
endmodule

// File: rtl/memcfg_switch_bank.sv
module memcfg_switch_bank
   import memcfg_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              io_sel,
   input  logic              cpu_rw,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic              bank2_in,
   input  logic              rdram_in,
   input  logic [DATA_W-1:0] float_in,
   output logic [NUM_SW-1:0] sw_flags,
   output logic [DATA_W-1:0] rd_data
);
   if (ADDR_W < 5) begin : g_bad_addr
      $error("memcfg_switch_bank: ADDR_W must cover offset $18");
   end
   if (DATA_W < 2) begin : g_bad_data
      $error("memcfg_switch_bank: DATA_W must be at least 2");
   end

   logic [NUM_SW-1:0] upd_en;
   logic              upd_val;

   memcfg_wr_decode #(.ADDR_W(ADDR_W)) u_dec (
      .io_sel   (io_sel),
      .cpu_rw   (cpu_rw),
      .cpu_addr (cpu_addr),
      .upd_en   (upd_en),
      .upd_val  (upd_val)
   );

   memcfg_flag_bank u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .upd_en  (upd_en),
      .upd_val (upd_val),
      .flags   (sw_flags)
   );

   memcfg_status_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mux (
      .io_sel   (io_sel),
      .cpu_rw   (cpu_rw),
      .cpu_addr (cpu_addr),
      .flags    (sw_flags),
      .bank2_in (bank2_in),
      .rdram_in (rdram_in),
      .float_in (float_in),
      .rd_data  (rd_data)
   );
endmodule

// File: rtl/memcfg_switch_bank_chk.sv
module memcfg_switch_bank_chk
   import memcfg_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              io_sel,
   input logic              cpu_rw,
   input logic [ADDR_W-1:0] cpu_addr,
   input logic              bank2_in,
   input logic              rdram_in,
   input logic [DATA_W-1:0] float_in,
   input logic [NUM_SW-1:0] sw_flags,
   input logic [DATA_W-1:0] rd_data
);
   logic sw_wr, st_rd, any_st_rd;
   assign sw_wr     = io_sel && !cpu_rw && (cpu_addr < ADDR_W'(OFS_WR_END));
   assign st_rd     = io_sel && cpu_rw && (cpu_addr >= ADDR_W'(OFS_ST_LO))
                      && (cpu_addr < ADDR_W'(OFS_ST_LO + NUM_SW));
   assign any_st_rd = io_sel && cpu_rw && (cpu_addr >= ADDR_W'(OFS_BANK2))
                      && (cpu_addr < ADDR_W'(OFS_ST_LO + NUM_SW));

   logic [2:0] st_sel;
   always_comb begin
      st_sel = 3'(cpu_addr - ADDR_W'(OFS_ST_LO - 1));
      if (st_sel == 3'(NUM_SW)) st_sel = 3'd0;
   end

   p_reset_clear_r1: assert property (@(posedge clk)
      !rst_n |-> sw_flags == '0);

   p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
      sw_wr |=> sw_flags[$past(cpu_addr[3:1])] == $past(cpu_addr[0]));

   p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !sw_wr |=> $stable(sw_flags));

   p_status_bit_r6: assert property (@(posedge clk) disable iff (!rst_n)
      st_rd |-> rd_data[DATA_W-1] == sw_flags[st_sel]);

   p_bank_status_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (io_sel && cpu_rw && cpu_addr == ADDR_W'(OFS_BANK2)) |-> rd_data[DATA_W-1] == bank2_in);

   p_low_bits_r8: assert property (@(posedge clk) disable iff (!rst_n)
      any_st_rd |-> rd_data[DATA_W-2:0] == float_in[DATA_W-2:0]);

   p_idle_float_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !io_sel |-> rd_data == float_in);
endmodule

bind memcfg_switch_bank memcfg_switch_bank_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .io_sel   (io_sel),
   .cpu_rw   (cpu_rw),
   .cpu_addr (cpu_addr),
   .bank2_in (bank2_in),
   .rdram_in (rdram_in),
   .float_in (float_in),
   .sw_flags (sw_flags),
   .rd_data  (rd_data)
);

// File: tb/memcfg_switch_bank_tb.sv
module memcfg_switch_bank_tb;
   logic       clk = 1'b0;
   logic       rst_n;
   logic       io_sel = 1'b0;
   logic       cpu_rw = 1'b1;
   logic [7:0] cpu_addr = '0;
   logic       bank2_in = 1'b0;
   logic       rdram_in = 1'b0;
   logic [7:0] float_in = 8'h5A;
   logic [5:0] sw_flags;
   logic [7:0] rd_data;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   memcfg_switch_bank u_dut (
      .clk(clk), .rst_n(rst_n), .io_sel(io_sel), .cpu_rw(cpu_rw),
      .cpu_addr(cpu_addr), .bank2_in(bank2_in), .rdram_in(rdram_in),
      .float_in(float_in), .sw_flags(sw_flags), .rd_data(rd_data)
   );

   // {write offset, flags after, status offset, expected bit 7}
   localparam int NV = 16;
   localparam logic [22:0] VEC [NV] = '{
      {8'h01, 6'b000001, 8'h18, 1'b1},
      {8'h03, 6'b000011, 8'h13, 1'b1},
      {8'h05, 6'b000111, 8'h14, 1'b1},
      {8'h07, 6'b001111, 8'h15, 1'b1},
      {8'h09, 6'b011111, 8'h16, 1'b1},
      {8'h0B, 6'b111111, 8'h17, 1'b1},
      {8'h00, 6'b111110, 8'h18, 1'b0},
      {8'h02, 6'b111100, 8'h13, 1'b0},
      {8'h04, 6'b111000, 8'h14, 1'b0},
      {8'h06, 6'b110000, 8'h15, 1'b0},
      {8'h08, 6'b100000, 8'h16, 1'b0},
      {8'h0A, 6'b000000, 8'h17, 1'b0},
      {8'h0B, 6'b100000, 8'h13, 1'b0},
      {8'h07, 6'b101000, 8'h15, 1'b1},
      {8'h0C, 6'b101000, 8'h17, 1'b1},
      {8'h15, 6'b101000, 8'h16, 1'b0}
   };

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic do_write(input logic [7:0] a);
      @(negedge clk);
      io_sel = 1'b1; cpu_rw = 1'b0; cpu_addr = a;
      @(negedge clk);
      io_sel = 1'b0; cpu_rw = 1'b1;
      #1;
   endtask

   task automatic do_read(input logic [7:0] a, output logic [7:0] d);
      @(negedge clk);
      io_sel = 1'b1; cpu_rw = 1'b1; cpu_addr = a;
      #1 d = rd_data;
      @(negedge clk);
      io_sel = 1'b0;
      #1;
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [7:0] d;
      rst_n = 1'b0;
      #1;
      chk(sw_flags == 6'b0, "R1 reset flags", 32'(sw_flags), 0);
      #20 @(negedge clk) rst_n = 1'b1;
      #1 chk(sw_flags == 6'b0, "R1 flags after release", 32'(sw_flags), 0);
      do_read(8'h15, d);
      chk(d[7] == 1'b0, "R1 internal Cx ROM clear after reset", 32'(d[7]), 0);

      for (int i = 0; i < NV; i++) begin
         logic [7:0] wa, sa; logic [5:0] ef; logic eb;
         {wa, ef, sa, eb} = VEC[i];
         do_write(wa);
         chk(sw_flags == ef, (wa < 8'h0C) ? "R2/R3 flag vector" : "R5 ignored write",
             32'(sw_flags), 32'(ef));
         do_read(sa, d);
         chk(d[7] == eb, "R6 status bit", 32'(d[7]), 32'(eb));
         chk(d[6:0] == float_in[6:0], "R8 low bits", 32'(d[6:0]), 32'(float_in[6:0]));
      end

      // R3 inverted sense: $06 selects slot ROM, $07 internal
      do_write(8'h06);
      chk(sw_flags[3] == 1'b0, "R3 $06 clears internal ROM", 32'(sw_flags[3]), 0);

      // R4 timing: not visible before the edge, visible after
      @(negedge clk);
      io_sel = 1'b1; cpu_rw = 1'b0; cpu_addr = 8'h03;
      #1 chk(sw_flags[1] == 1'b0, "R4 before edge", 32'(sw_flags[1]), 0);
      @(posedge clk); #1;
      chk(sw_flags[1] == 1'b1, "R4 after edge", 32'(sw_flags[1]), 1);
      @(negedge clk); io_sel = 1'b0; cpu_rw = 1'b1;

      // R5 read cycle at a switch address does not change flags
      do_read(8'h02, d);
      chk(sw_flags[1] == 1'b1, "R5 read at switch address", 32'(sw_flags[1]), 1);
      chk(d == float_in, "R8 non-status read floats", 32'(d), 32'(float_in));

      // R9 no access without io_sel
      @(negedge clk); io_sel = 1'b0; cpu_rw = 1'b0; cpu_addr = 8'h02;
      @(negedge clk); cpu_rw = 1'b1; #1;
      chk(sw_flags[1] == 1'b1, "R9 io_sel low", 32'(sw_flags[1]), 1);
      chk(rd_data == float_in, "R8 idle bus", 32'(rd_data), 32'(float_in));

      // R7 bank status inputs
      float_in = 8'hA5; bank2_in = 1'b1; rdram_in = 1'b0;
      do_read(8'h11, d);
      chk(d == 8'hA5, "R7 bank2 high", 32'(d), 32'hA5);
      do_read(8'h12, d);
      chk(d == 8'h25, "R7 rdram low", 32'(d), 32'h25);
      bank2_in = 1'b0; rdram_in = 1'b1; float_in = 8'h00;
      do_read(8'h11, d);
      chk(d == 8'h00, "R7 bank2 low", 32'(d), 0);
      do_read(8'h12, d);
      chk(d == 8'h80, "R7 rdram high", 32'(d), 32'h80);

      // R1 asynchronous reset mid-run
      do_write(8'h0B);
      @(negedge clk); #2 rst_n = 1'b0; #1;
      chk(sw_flags == 6'b0, "R1 async reset", 32'(sw_flags), 0);
      @(negedge clk) rst_n = 1'b1;

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule